// File: doc/BRIEF.md
# Dirty Line Write-Back Staging Buffer

This block sits between a data cache and the memory write path. When the cache evicts a line or runs a clean operation, it hands over the whole line in one cycle: eight data words, the physical address the line was filled from, and two dirty flags, one for each half of the line. The cache can then refill the freed slot at once, while the buffer drains the line to memory in the background, one word per accepted transfer.

The two dirty flags set how much is written. Both flags set sends the whole line. One flag set sends only that half, so an upper-half-only drain starts at word 4, sixteen bytes past the line address. No flag set sends nothing. The address on each output beat is the stored address plus the byte offset of the word, so no translation takes part in the write-back. While a line is draining, the buffer refuses new lines.

Top module: `line_evict_buf`

## Requirements
- R1: During and right after reset, `busy` and `wr_valid` are 0 and `ld_ready` is 1.
- R2: A line loaded with `ld_dirty` = 2'b11 is written out as words 0 to 7 in ascending order. Word k is the k-th 32-bit field of `ld_data` (bits 32k+31 down to 32k). Its address is `ld_addr` + 4k.
- R3: A line loaded with `ld_dirty` = 2'b01 (bit 0 marks words 0-3 dirty) writes out words 0 to 3 only, at `ld_addr` to `ld_addr` + 12.
- R4: A line loaded with `ld_dirty` = 2'b10 (bit 1 marks words 4-7 dirty) writes out words 4 to 7 only. The first beat carries address `ld_addr` + 16.
- R5: A load with `ld_dirty` = 2'b00 is accepted but never asserts `busy` or `wr_valid`, and `ld_ready` stays 1.
- R6: While `busy` is 1, `ld_ready` is 0 and any `ld_valid` is ignored: the line being drained keeps its data, address and range.
- R7: `wr_last` is 1 exactly on the final beat of the chosen range, and only while `wr_valid` is 1.
- R8: While `wr_valid` is 1 and `wr_ready` is 0, the next cycle still shows `wr_valid` with unchanged `wr_addr` and `wr_data`.
- R9: `busy` falls in the cycle after the beat with `wr_last` is accepted. `busy` rises in the cycle after a load with a nonzero dirty mask is accepted. `ld_ready` is the inverse of `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Cache offers a line |
| ld_ready | output | 1 | Buffer can take a line |
| ld_addr | input | 32 | Line-aligned physical address of the line |
| ld_data | input | 256 | Eight line words, word k at bits 32k+31:32k |
| ld_dirty | input | 2 | Bit 0: words 0-3 dirty; bit 1: words 4-7 dirty |
| busy | output | 1 | A line is being drained |
| wr_valid | output | 1 | Output beat valid |
| wr_ready | input | 1 | Memory side accepts the beat |
| wr_addr | output | 32 | Byte address of the beat |
| wr_data | output | 32 | Data word of the beat |
| wr_last | output | 1 | Final beat of the range |

## Verification
The assertions check on every cycle that a stalled beat holds still, that accepted beats step the address by one word, that `busy` drops right after the final beat, that an empty-mask load never raises `busy`, and that an upper-half drain opens at the sixteen-byte offset. Only the bench scenarios can show that the exact set of words leaves in order with the right data for each dirty mask, and that a line offered during a drain leaves the held line untouched.

// File: rtl/evb_pkg.sv
package evb_pkg;

  typedef enum logic {
    EVB_IDLE  = 1'b0,
    EVB_DRAIN = 1'b1
  } evb_state_e;

endpackage

// File: rtl/evb_span.sv
// Maps the two half-line dirty flags onto the first and final word index.
module evb_span #(
  parameter int WORDS = 8,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic [1:0]       dirty,
  output logic [IDX_W-1:0] first_idx,
  output logic [IDX_W-1:0] final_idx,
  output logic             any_dirty
);
  localparam int HALF = WORDS / 2;

  always_comb begin
    first_idx = dirty[0] ? '0 : IDX_W'(HALF);
    final_idx = dirty[1] ? IDX_W'(WORDS - 1) : IDX_W'(HALF - 1);
    any_dirty = |dirty;
  end
endmodule

// File: rtl/evb_hold.sv
// Line storage: one address register and one register per word.
module evb_hold #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int WORDS  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_en,
  input  logic [ADDR_W-1:0]       addr_in,
  input  logic [WORDS*DATA_W-1:0] line_in,
  output logic [ADDR_W-1:0]       addr_q,
  output logic [DATA_W-1:0]       word_q [WORDS]
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (cap_en) begin
      addr_q <= addr_in;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[w] <= '0;
      end else if (cap_en) begin
        word_q[w] <= line_in[w*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/evb_seq.sv
// Drain sequencer: walks the word index from the first to the final word.
module evb_seq #(
  parameter int WORDS = 8,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] first_idx,
  input  logic [IDX_W-1:0] final_idx,
  input  logic             beat_fire,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             at_final
);
  import evb_pkg::*;

  evb_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] stop_q, stop_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    stop_d  = stop_q;
    unique case (state_q)
      EVB_IDLE: begin
        if (start) begin
          state_d = EVB_DRAIN;
          idx_d   = first_idx;
          stop_d  = final_idx;
        end
      end
      EVB_DRAIN: begin
        if (beat_fire) begin
          if (idx_q == stop_q) state_d = EVB_IDLE;
          else                 idx_d   = idx_q + 1'b1;
        end
      end
      default: state_d = EVB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= EVB_IDLE;
      idx_q   <= '0;
      stop_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      stop_q  <= stop_d;
    end
  end

  assign busy     = (state_q == EVB_DRAIN);
  assign idx      = idx_q;
  assign at_final = (idx_q == stop_q);
endmodule

// File: rtl/line_evict_buf.sv
module line_evict_buf #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int WORDS  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_valid,
  output logic                    ld_ready,
  input  logic [ADDR_W-1:0]       ld_addr,
  input  logic [WORDS*DATA_W-1:0] ld_data,
  input  logic [1:0]              ld_dirty,
  output logic                    busy,
  output logic                    wr_valid,
  input  logic                    wr_ready,
  output logic [ADDR_W-1:0]       wr_addr,
  output logic [DATA_W-1:0]       wr_data,
  output logic                    wr_last
);
  localparam int IDX_W = $clog2(WORDS);
  localparam int BSH   = $clog2(DATA_W / 8);

  logic [IDX_W-1:0]  first_idx, final_idx, idx;
  logic              any_dirty, start, at_final, beat_fire, busy_i;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] word_q [WORDS];

  evb_span #(.WORDS(WORDS)) u_span (
    .dirty     (ld_dirty),
    .first_idx (first_idx),
    .final_idx (final_idx),
    .any_dirty (any_dirty)
  );

  assign start     = ld_valid && !busy_i && any_dirty;
  assign beat_fire = busy_i && wr_ready;

  evb_hold #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORDS(WORDS)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (start),
    .addr_in (ld_addr),
    .line_in (ld_data),
    .addr_q  (addr_q),
    .word_q  (word_q)
  );

  evb_seq #(.WORDS(WORDS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .first_idx (first_idx),
    .final_idx (final_idx),
    .beat_fire (beat_fire),
    .busy      (busy_i),
    .idx       (idx),
    .at_final  (at_final)
  );

  always_comb begin
    busy     = busy_i;
    ld_ready = !busy_i;
    wr_valid = busy_i;
    wr_last  = busy_i && at_final;
    wr_data  = word_q[idx];
    wr_addr  = addr_q + (ADDR_W'(idx) << BSH);
  end
endmodule

// File: rtl/line_evict_buf_chk.sv
module line_evict_buf_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int WORDS  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_valid,
  input logic              ld_ready,
  input logic [ADDR_W-1:0] ld_addr,
  input logic [1:0]        ld_dirty,
  input logic              busy,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_last
);
  localparam int BYTES = DATA_W / 8;
  localparam int HALF_OFS = (WORDS / 2) * BYTES;

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !wr_last) |=> (wr_valid && wr_addr == $past(wr_addr) + ADDR_W'(BYTES)));

  assert_busy_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_last) |=> !busy);

  assert_empty_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready && ld_dirty == 2'b00) |=> (!busy && !wr_valid));

  assert_upper_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready && ld_dirty == 2'b10) |=> (wr_valid && wr_addr == $past(ld_addr) + ADDR_W'(HALF_OFS)));

  assert_last_framed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_last |-> wr_valid);

  assert_refuse_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(wr_ready && wr_last)) |=> busy);
endmodule

bind line_evict_buf line_evict_buf_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORDS(WORDS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ld_valid (ld_valid),
  .ld_ready (ld_ready),
  .ld_addr  (ld_addr),
  .ld_dirty (ld_dirty),
  .busy     (busy),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .wr_last  (wr_last)
);

// File: tb/line_evict_buf_test.sv
`timescale 1ns/1ps
module line_evict_buf_test;
  logic         clk;
  logic         rst_n;
  logic         ld_valid;
  logic         ld_ready;
  logic [31:0]  ld_addr;
  logic [255:0] ld_data;
  logic [1:0]   ld_dirty;
  logic         busy;
  logic         wr_valid;
  logic         wr_ready;
  logic [31:0]  wr_addr;
  logic [31:0]  wr_data;
  logic         wr_last;

  int n_chk;
  int n_fail;

  line_evict_buf uut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_data(ld_data), .ld_dirty(ld_dirty), .busy(busy),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_last(wr_last)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Vector fields: [37:36] dirty mask, [35:32] ready pattern, [31:0] line address
  localparam logic [37:0] VEC [6] = '{
    {2'b11, 4'b1111, 32'h0000_1000},
    {2'b01, 4'b1111, 32'h8000_0040},
    {2'b10, 4'b1111, 32'h1234_5660},
    {2'b11, 4'b0101, 32'hFFFF_FFE0},
    {2'b10, 4'b0110, 32'h0000_00A0},
    {2'b01, 4'b1100, 32'hDEAD_BE00}
  };

  function automatic logic [31:0] word_val(int tag, int k);
    return 32'hC0DE_0000 | (32'(tag) << 8) | 32'(k);
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Offer a line at a negedge; it is taken at the following posedge.
  task automatic load(logic [31:0] a, int tag, logic [1:0] d);
    @(negedge clk);
    ld_valid = 1'b1;
    ld_addr  = a;
    ld_dirty = d;
    for (int k = 0; k < 8; k++) ld_data[k*32 +: 32] = word_val(tag, k);
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  // Drain the line now held, stepping wr_ready through a 4-bit pattern.
  task automatic drain(string req, logic [31:0] a, int tag, logic [1:0] d, logic [3:0] pat);
    int e;
    int last_e;
    int c;
    e      = d[0] ? 0 : 4;
    last_e = d[1] ? 7 : 3;
    c      = 0;
    while (e <= last_e && c < 100) begin
      check({req, " wr_valid"}, 64'(wr_valid), 64'd1);
      check("R6 ld_ready low while busy", 64'(ld_ready), 64'd0);
      wr_ready = pat[c % 4];
      if (pat[c % 4]) begin
        check({req, " addr"}, 64'(wr_addr), 64'(a + 32'(4 * e)));
        check({req, " data"}, 64'(wr_data), 64'(word_val(tag, e)));
        check("R7 last flag", 64'(wr_last), 64'(e == last_e));
        e++;
      end
      c++;
      @(negedge clk);
    end
    wr_ready = 1'b0;
    check("R9 busy falls after final beat", 64'(busy), 64'd0);
    check("R9 ld_ready back", 64'(ld_ready), 64'd1);
    check("R7 no last when idle", 64'(wr_last), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] held_a;
    n_chk    = 0;
    n_fail   = 0;
    rst_n    = 1'b0;
    ld_valid = 1'b0;
    ld_addr  = '0;
    ld_data  = '0;
    ld_dirty = 2'b00;
    wr_ready = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", 64'(busy), 64'd0);
    check("R1 wr_valid in reset", 64'(wr_valid), 64'd0);
    check("R1 ld_ready in reset", 64'(ld_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", 64'(busy), 64'd0);
    check("R1 wr_valid after reset", 64'(wr_valid), 64'd0);

    // Table walk: R2 full line, R3 lower half, R4 upper half, R8 stalls
    for (int v = 0; v < 6; v++) begin
      logic [1:0] d;
      d = VEC[v][37:36];
      load(VEC[v][31:0], v, d);
      check("R9 busy rises after load", 64'(busy), 64'd1);
      drain(d == 2'b11 ? "R2" : (d == 2'b01 ? "R3" : "R4"),
            VEC[v][31:0], v, d, VEC[v][35:32]);
    end

    // R8: hold a beat stalled and confirm it does not move
    load(32'h0000_2000, 20, 2'b11);
    repeat (3) begin
      check("R8 stalled addr", 64'(wr_addr), 64'h2000);
      check("R8 stalled data", 64'(wr_data), 64'(word_val(20, 0)));
      @(negedge clk);
    end

    // R6: offer another line during the drain; it must be ignored
    ld_valid = 1'b1;
    ld_addr  = 32'h0000_3000;
    ld_dirty = 2'b10;
    for (int k = 0; k < 8; k++) ld_data[k*32 +: 32] = word_val(21, k);
    repeat (2) @(negedge clk);
    ld_valid = 1'b0;
    check("R6 addr kept", 64'(wr_addr), 64'h2000);
    check("R6 data kept", 64'(wr_data), 64'(word_val(20, 0)));
    held_a = 32'h0000_2000;
    drain("R6", held_a, 20, 2'b11, 4'b1111);

    // R5: empty mask
    load(32'h0000_4000, 22, 2'b00);
    repeat (3) begin
      check("R5 busy stays low", 64'(busy), 64'd0);
      check("R5 wr_valid stays low", 64'(wr_valid), 64'd0);
      check("R5 ld_ready stays high", 64'(ld_ready), 64'd1);
      @(negedge clk);
    end

    // R9: back-to-back lines, second one right after busy clears
    load(32'h0000_5000, 23, 2'b01);
    drain("R3", 32'h0000_5000, 23, 2'b01, 4'b1111);
    load(32'h0000_6000, 24, 2'b10);
    check("R4 first addr", 64'(wr_addr), 64'h6010);
    drain("R4", 32'h0000_6000, 24, 2'b10, 4'b1001);

    summary();
  end
endmodule